// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is one 32-bit timer channel. Its counting clock comes from the system clock, taken either every cycle or once every sixteen cycles, or from an external clock pin that is synchronized on chip. An 8-bit prescaler sits behind the source select, and its wrap pulse advances a free-running counter. In compare mode the channel raises an event when the counter meets a reference value, and it can optionally restart from zero at that point. In capture mode a rising edge on the capture pin copies the counter into a capture register. In both modes an event sets a sticky flag.

Software sees five word registers through one shared address for reads and writes. Each event is routed either to an interrupt line or to a DMA request line. A small request state machine with three states owns both lines. REQ_IDLE moves to REQ_IRQ or REQ_DMA on an enabled event, depending on the routing bit. REQ_IRQ returns to REQ_IDLE when software clears the flag. REQ_DMA returns to REQ_IDLE when the acknowledge input is pulsed. If a new event arrives in the same cycle as the clear, the machine stays in its current state.

Top module: `tmr_capcmp`

## Requirements
- R1: After reset, every register reads zero and both `irq` and `dma_req` are low.
- R2: The control register (address 0) holds: bit 0 run, bits 2:1 source, bit 3 capture mode, bit 4 restart on match, bit 5 event enable, bit 6 route to DMA, bits 15:8 prescale. Source code 0 selects the system clock, code 1 selects the system clock divided by 16, code 2 selects the external clock, and code 3 gives no ticks.
- R3: A prescale value N advances the counter once every N+1 source ticks. After run is written, the first tick lands on source tick N+1.
- R4: The external clock passes through two synchronizer flops, and only its rising edge is a source tick. The counter changes on the third clock edge after the pin rises.
- R5: The reference is at address 1, and the counter is at address 3, which a write loads. In compare mode, a tick while the counter equals the reference sets the event flag. That tick loads zero when restart is set and increments the counter otherwise.
- R6: In capture mode, with run set, a rising edge on `cap_in` is synchronized by two flops. On the third clock edge after the pin rises, the counter value is copied into the capture register (address 2, read-only) and the flag is set. The capture register changes at no other time.
- R7: The event flag is bit 0 of the status register (address 4). Writing 1 to that bit clears the flag, and writing 0 leaves it unchanged. In REQ_IRQ, clearing the flag drops `irq`.
- R8: An event with event enable set goes to `dma_req` when route-to-DMA is 1, and to `irq` otherwise. With event enable cleared, an event sets the flag but raises neither line.
- R9: `dma_req` stays high until `dma_ack` is pulsed, and the acknowledge also clears the flag. An acknowledge has no effect when no DMA request is pending.
- R10: While run is 0, the counter holds its value and the prescaler and the divide-by-16 stage return to zero.
- R11: `irq` and `dma_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| ext_clk | input | 1 | External counting clock, asynchronous |
| cap_in | input | 1 | Capture input, asynchronous |
| dma_ack | input | 1 | Acknowledge pulse for the DMA request |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
A prescale or divider counter stuck at a wrong phase shows up as a counter readback that is off by one or more ticks. This appears within one prescale period, so the vector table reads the counter at exact edge counts. A request state machine in the wrong state shows up as a line that drops without a clear or an acknowledge, or as both lines high at once. The checker flags either case on the next edge. Synchronizer depth errors move capture values and first external ticks by a whole cycle. The directed tests sample exactly at the third edge to catch this.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W  = 32;
    localparam int PSC_W  = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_REF  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CAP  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

    typedef enum logic [1:0] {
        SRC_SYS  = 2'd0,
        SRC_SLOW = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_OFF  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        REQ_IDLE = 2'd0,
        REQ_IRQ  = 2'd1,
        REQ_DMA  = 2'd2
    } req_state_e;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
    import tmr_pkg::*;
#(
    parameter int PSC_W    = 8,
    parameter int SLOW_DIV = 16,
    parameter int SYNC_N   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       src,
    input  logic [PSC_W-1:0] psc,
    input  logic             ext_clk,
    output logic             cnt_tick
);
    localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

    logic [SYNC_N:0]  ext_sync;
    logic             ext_rise;
    logic             slow_tick;
    logic             src_tick;
    logic [PSC_W-1:0] pcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_sync <= '0;
        else        ext_sync <= {ext_sync[SYNC_N-1:0], ext_clk};
    end
    assign ext_rise = ext_sync[SYNC_N-1] & ~ext_sync[SYNC_N];

    generate
        if (SLOW_DIV > 1) begin : g_div
            logic [DIV_W-1:0] dcnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                              dcnt <= '0;
                else if (!run)                           dcnt <= '0;
                else if (dcnt == DIV_W'(SLOW_DIV - 1))   dcnt <= '0;
                else                                     dcnt <= dcnt + 1'b1;
            end
            assign slow_tick = (dcnt == DIV_W'(SLOW_DIV - 1));
        end else begin : g_nodiv
            assign slow_tick = 1'b1;
        end
    endgenerate

    always_comb begin
        unique case (src_e'(src))
            SRC_SYS:  src_tick = 1'b1;
            SRC_SLOW: src_tick = slow_tick;
            SRC_EXT:  src_tick = ext_rise;
            SRC_OFF:  src_tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pcnt <= '0;
        else if (!run)     pcnt <= '0;
        else if (src_tick) pcnt <= (pcnt >= psc) ? '0 : pcnt + 1'b1;
    end

    assign cnt_tick = run & src_tick & (pcnt >= psc);
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int CNT_W  = 32,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cnt_tick,
    input  logic             cap_mode,
    input  logic             restart,
    input  logic [CNT_W-1:0] ref_val,
    input  logic             cap_in,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap_val,
    output logic             flag,
    output logic             evt
);
    logic [SYNC_N:0] cap_sync;
    logic            cap_rise;
    logic            match;
    logic            cap_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_sync <= '0;
        else        cap_sync <= {cap_sync[SYNC_N-1:0], cap_in};
    end
    assign cap_rise = cap_sync[SYNC_N-1] & ~cap_sync[SYNC_N];

    assign match   = ~cap_mode & cnt_tick & (count == ref_val);
    assign cap_evt = cap_mode & run & cap_rise;
    assign evt     = match | cap_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             count <= '0;
        else if (load_en)       count <= load_val;
        else if (cnt_tick)      count <= (match && restart) ? '0 : count + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cap_val <= '0;
        else if (cap_evt) cap_val <= count;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag <= 1'b0;
        else if (evt)      flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end
endmodule

// File: rtl/tmr_req_fsm.sv
module tmr_req_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic ev_en,
    input  logic route_dma,
    input  logic sw_clr,
    input  logic dma_ack,
    output logic irq,
    output logic dma_req
);
    req_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= REQ_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            REQ_IDLE: if (evt && ev_en) state_nx = route_dma ? REQ_DMA : REQ_IRQ;
            REQ_IRQ:  if (sw_clr && !evt) state_nx = REQ_IDLE;
            REQ_DMA:  if (dma_ack && !evt) state_nx = REQ_IDLE;
            default:  state_nx = REQ_IDLE;
        endcase
    end

    always_comb begin
        irq     = (state == REQ_IRQ);
        dma_req = (state == REQ_DMA);
    end
endmodule

// File: rtl/tmr_capcmp.sv
module tmr_capcmp
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic              ext_clk,
    input  logic              cap_in,
    input  logic              dma_ack,
    output logic              irq,
    output logic              dma_req
);
    logic [15:0]      ctrl_q;
    logic [CNT_W-1:0] ref_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] cap_q;
    logic             flag_q;
    logic             evt;
    logic             cnt_tick;
    logic             run, cap_mode, restart, ev_en, route_dma;
    logic [1:0]       src;
    logic [PSC_W-1:0] psc;
    logic             load_en, w1c, flag_clr;

    assign run       = ctrl_q[0];
    assign src       = ctrl_q[2:1];
    assign cap_mode  = ctrl_q[3];
    assign restart   = ctrl_q[4];
    assign ev_en     = ctrl_q[5];
    assign route_dma = ctrl_q[6];
    assign psc       = ctrl_q[15:8];

    assign load_en  = wr_en && (addr == A_CNT);
    assign w1c      = wr_en && (addr == A_STAT) && wdata[0];
    assign flag_clr = w1c | (dma_ack & dma_req);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ref_q  <= '0;
        end else if (wr_en) begin
            if (addr == A_CTRL) ctrl_q <= wdata[15:0];
            if (addr == A_REF)  ref_q  <= wdata;
        end
    end

    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = {{(CNT_W-16){1'b0}}, ctrl_q};
            A_REF:   rdata = ref_q;
            A_CAP:   rdata = cap_q;
            A_CNT:   rdata = count_q;
            A_STAT:  rdata = {{(CNT_W-1){1'b0}}, flag_q};
            default: rdata = '0;
        endcase
    end

    tmr_tick_gen #(.PSC_W(PSC_W), .SLOW_DIV(16), .SYNC_N(2)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .src(src), .psc(psc),
        .ext_clk(ext_clk), .cnt_tick(cnt_tick)
    );

    tmr_core #(.CNT_W(CNT_W), .SYNC_N(2)) u_core (
        .clk(clk), .rst_n(rst_n), .run(run), .cnt_tick(cnt_tick),
        .cap_mode(cap_mode), .restart(restart), .ref_val(ref_q),
        .cap_in(cap_in), .load_en(load_en), .load_val(wdata),
        .flag_clr(flag_clr), .count(count_q), .cap_val(cap_q),
        .flag(flag_q), .evt(evt)
    );

    tmr_req_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .evt(evt), .ev_en(ev_en),
        .route_dma(route_dma), .sw_clr(w1c), .dma_ack(dma_ack),
        .irq(irq), .dma_req(dma_req)
    );
endmodule

// File: rtl/tmr_capcmp_chk.sv
module tmr_capcmp_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             dma_req,
    input logic             dma_ack,
    input logic             w1c,
    input logic             run,
    input logic             load_en,
    input logic             cap_mode,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] cap_q
);
    // R11
    a_r11_lines_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && dma_req));

    // R9
    a_r9_dma_held: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_req) |-> $past(dma_ack));

    // R7
    a_r7_irq_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(w1c));

    // R10
    a_r10_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(run) && !$past(load_en)) |-> $stable(count_q));

    // R5
    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_en) |-> (count_q == $past(count_q) ||
                             count_q == $past(count_q) + 1'b1 ||
                             count_q == '0));

    // R6
    a_r6_cap_only_in_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cap_mode) |-> $stable(cap_q));
endmodule

bind tmr_capcmp tmr_capcmp_chk #(.CNT_W(tmr_pkg::CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .dma_req(dma_req),
    .dma_ack(dma_ack), .w1c(w1c), .run(run), .load_en(load_en),
    .cap_mode(cap_mode), .count_q(count_q), .cap_q(cap_q)
);

// File: tb/tmr_capcmp_bench.sv
`timescale 1ns/1ps
module tmr_capcmp_bench;
    import tmr_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [CNT_W-1:0]  wdata = '0;
    logic [CNT_W-1:0]  rdata;
    logic              ext_clk = 1'b0;
    logic              cap_in = 1'b0;
    logic              dma_ack = 1'b0;
    logic              irq, dma_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tmr_capcmp u_tmr_capcmp (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ext_clk(ext_clk), .cap_in(cap_in), .dma_ack(dma_ack),
        .irq(irq), .dma_req(dma_req)
    );

    typedef struct packed {
        logic [1:0]  src;
        logic [7:0]  psc;
        logic [15:0] k;
        logic [15:0] exp;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{2'd0, 8'd0,   16'd10,  16'd10},
        '{2'd0, 8'd3,   16'd20,  16'd5},
        '{2'd0, 8'd4,   16'd23,  16'd4},
        '{2'd1, 8'd0,   16'd48,  16'd3},
        '{2'd1, 8'd1,   16'd100, 16'd3},
        '{2'd1, 8'd2,   16'd200, 16'd4},
        '{2'd0, 8'd255, 16'd600, 16'd2}
    };

    function automatic logic [31:0] mk_ctrl(bit run, logic [1:0] src, bit cap,
                                            bit rst, bit ev, bit dma, logic [7:0] psc);
        return {16'd0, psc, 1'b0, dma, ev, rst, cap, src, run};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, v); chk("R1 ctrl", v, 0);
        rd(A_REF, v);  chk("R1 ref", v, 0);
        rd(A_CAP, v);  chk("R1 cap", v, 0);
        rd(A_CNT, v);  chk("R1 count", v, 0);
        rd(A_STAT, v); chk("R1 status", v, 0);
        chk("R1 irq", irq, 0);
        chk("R1 dma_req", dma_req, 0);

        // R2 R3 vector table: source select and prescale
        foreach (VECS[i]) begin
            wr(A_CTRL, 0);
            wr(A_CNT, 0);
            wr(A_CTRL, mk_ctrl(1, VECS[i].src, 0, 0, 0, 0, VECS[i].psc));
            repeat (VECS[i].k) @(posedge clk);
            @(negedge clk);
            rd(A_CNT, v);
            chk("R3 prescale/source count", v, 32'(VECS[i].exp));
        end

        // R2 source code 3 yields no ticks
        wr(A_CTRL, 0); wr(A_CNT, 0);
        wr(A_CTRL, mk_ctrl(1, 2'd3, 0, 0, 0, 0, 8'd0));
        repeat (20) @(negedge clk);
        rd(A_CNT, v); chk("R2 source off", v, 0);

        // R4 external clock with synchronizer latency
        wr(A_CTRL, 0); wr(A_CNT, 0);
        wr(A_CTRL, mk_ctrl(1, 2'd2, 0, 0, 0, 0, 8'd0));
        ext_clk = 1'b1;
        repeat (2) @(negedge clk);
        rd(A_CNT, v); chk("R4 ext before third edge", v, 0);
        @(negedge clk);
        rd(A_CNT, v); chk("R4 ext at third edge", v, 1);
        ext_clk = 1'b0;
        repeat (2) @(negedge clk);
        for (int p = 0; p < 4; p++) begin
            ext_clk = 1'b1; repeat (2) @(negedge clk);
            ext_clk = 1'b0; repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        rd(A_CNT, v); chk("R4 ext rising edges", v, 5);

        // R5 compare with restart, routed to irq (R8)
        wr(A_CTRL, 0); wr(A_CNT, 0); wr(A_REF, 5);
        wr(A_CTRL, mk_ctrl(1, 2'd0, 0, 1, 1, 0, 8'd0));
        repeat (5) @(negedge clk);
        rd(A_CNT, v); chk("R5 count before match", v, 5);
        chk("R8 irq before match", irq, 0);
        @(negedge clk);
        rd(A_CNT, v); chk("R5 restart to zero", v, 0);
        rd(A_STAT, v); chk("R5 flag on match", v, 1);
        chk("R8 irq on match", irq, 1);
        chk("R8 no dma when irq routed", dma_req, 0);
        wr(A_CTRL, 0);
        // R9 ack ignored without DMA pending
        @(negedge clk); dma_ack = 1'b1; @(negedge clk); dma_ack = 1'b0;
        chk("R9 ack ignored irq", irq, 1);
        rd(A_STAT, v); chk("R9 ack ignored flag", v, 1);
        // R7 write 0 then write 1
        wr(A_STAT, 0);
        rd(A_STAT, v); chk("R7 write zero keeps flag", v, 1);
        chk("R7 irq kept", irq, 1);
        wr(A_STAT, 1);
        rd(A_STAT, v); chk("R7 write one clears", v, 0);
        chk("R7 irq dropped", irq, 0);

        // R5 free-running past match
        wr(A_CNT, 0); wr(A_REF, 3);
        wr(A_CTRL, mk_ctrl(1, 2'd0, 0, 0, 1, 0, 8'd0));
        repeat (4) @(negedge clk);
        rd(A_CNT, v); chk("R5 no restart continues", v, 4);
        rd(A_STAT, v); chk("R5 flag free-run", v, 1);
        wr(A_CTRL, 0); wr(A_STAT, 1);

        // R8 event enable cleared
        wr(A_CNT, 0); wr(A_REF, 2);
        wr(A_CTRL, mk_ctrl(1, 2'd0, 0, 1, 0, 0, 8'd0));
        repeat (3) @(negedge clk);
        rd(A_STAT, v); chk("R8 flag without enable", v, 1);
        chk("R8 irq masked", irq, 0);
        chk("R8 dma masked", dma_req, 0);
        wr(A_CTRL, 0); wr(A_STAT, 1);

        // R6 capture routed to DMA (R8, R9)
        wr(A_CNT, 0);
        wr(A_CTRL, mk_ctrl(1, 2'd0, 1, 0, 1, 1, 8'd0));
        repeat (9) @(posedge clk);
        @(negedge clk);
        cap_in = 1'b1;
        repeat (2) @(negedge clk);
        rd(A_STAT, v); chk("R6 no flag before third edge", v, 0);
        @(negedge clk);
        rd(A_CAP, v); chk("R6 captured value", v, 11);
        rd(A_STAT, v); chk("R6 capture flag", v, 1);
        chk("R8 dma_req raised", dma_req, 1);
        chk("R11 irq low with dma", irq, 0);
        repeat (5) @(negedge clk);
        chk("R9 dma_req held", dma_req, 1);
        dma_ack = 1'b1; @(negedge clk); dma_ack = 1'b0;
        chk("R9 dma_req released", dma_req, 0);
        rd(A_STAT, v); chk("R9 ack clears flag", v, 0);
        rd(A_CAP, v); chk("R6 capture stable", v, 11);
        cap_in = 1'b0;

        // R10 hold while stopped
        wr(A_CTRL, 0);
        rd(A_CNT, held);
        repeat (10) @(negedge clk);
        rd(A_CNT, v); chk("R10 count held", v, held);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule